// File: doc/BRIEF.md
# Cascadable Timer Bank

This block holds four 8-bit up-counters grouped into two pairs: timers 0 and 1 form the first pair and timers 2 and 3 the second. Each timer has its own match value. A timer that reaches its match value raises a one-cycle interrupt request and starts counting again from zero. A mode bit per pair joins the two timers into one 16-bit counter. In that case the even timer is the low byte and the odd timer is the high byte. In 8-bit mode, the odd timer of a pair can count the match events of its even partner instead of the shared tick. Two counters chained this way give long periods without a 16-bit compare.

Software drives the block through a small byte-wide register bus. The bus sets match values, clock sources, pair modes and run bits. Counting advances on cycles where the prescaled `tick` input is high. A global run bit is ANDed with each timer's own run bit. A timer starts from zero when its combined run condition goes from false to true.

Top module: `tmrbank_top`

## Requirements
- R1: After reset, every register reads 0, all counters are 0 and no interrupt request is high.
- R2: Register map:
  - Offsets 0 to 3 hold the 8-bit match values of timers 0 to 3.
  - Offset 4 holds the clock-select byte, all bits kept.
  - Offset 5 holds the mode bits. Bit p joins pair p, and the other bits read 0.
  - Offset 6 holds the run byte. Bits 0 to 3 are the per-timer run bits and bit 7 is the global run bit. Bits 4 to 6 read 0.
  - Offset 7 reads 0.
- R3: A timer advances only on a cycle where `tick` is high and both its own run bit and the global run bit (bit 7) are set. With the global bit clear, or with `tick` low, no counter moves and no request rises.
- R4: Start and stop are set by writes to the run register.
  - A write that makes a timer's combined run condition newly true clears its counter to 0.
  - Rewriting the run register while the condition stays true leaves the count untouched.
  - A write that makes the condition false stops the timer, so it raises no further requests.
- R5: In 8-bit mode, a tick on which the counter equals the match value M clears the counter and raises the request. Started from 0, the first request follows tick M+1, and requests repeat every M+1 ticks, for every M from 0 to 255.
- R6: A request on `irq[i]` is high for exactly one clock cycle. That cycle is the one after the clock edge that took the matching tick.
- R7: Each timer has a 2-bit clock-select field at bits [2i+1:2i] of the clock-select byte. In 8-bit mode, an odd timer whose field is 00 advances once per match of its even partner. Any other field value makes it advance on `tick`. Even timers always advance on `tick`.
- R8: With a pair joined, the pair counts {odd, even} as one 16-bit value with carry from the low byte into the high byte. It matches only when both bytes equal their match values. It then clears both bytes and raises the even timer's request. The odd timer's request stays low, and only the even timer's run bit gates the pair.
- R9: A new match value written while a timer runs is used on the next tick's compare. If the new value is below the current count, the counter wraps through 255 before it matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 3 | Register offset |
| regWr | input | 1 | Write strobe for the addressed register |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data of the addressed register (combinational) |
| tick | input | 1 | Prescaled count enable, sampled each clock |
| irq | output | 4 | Per-timer match request, one-cycle pulse |

## Verification
The assertions assume that `tick` is a clean level, sampled once per clock, and that no request can arise except from a tick. They also assume the run and mode state seen in one cycle decides the request bits of the next cycle. The stimulus writes registers only while `tick` is low. This keeps every start, stop and mode change apart from counting, so each measured period begins from a known count. The sweeps change the match values, clock-select fields and modes only between runs, apart from the one case where a match value is deliberately rewritten mid-count.

// File: rtl/tmrbank_pkg.sv
package tmrbank_pkg;
  localparam int BYTE_W      = 8;
  localparam int NUM_PAIRS   = 2;
  localparam int NUM_TMR     = 2 * NUM_PAIRS;
  localparam int ADDR_W      = 3;
  localparam int CLK_FIELD_W = 2;
  localparam int GLOBAL_RUN_BIT = BYTE_W - 1;

  localparam logic [ADDR_W-1:0] OFS_CLKSEL = ADDR_W'(NUM_TMR);
  localparam logic [ADDR_W-1:0] OFS_MODE   = ADDR_W'(NUM_TMR + 1);
  localparam logic [ADDR_W-1:0] OFS_RUN    = ADDR_W'(NUM_TMR + 2);

  // Strobes from the control half to the counting half
  typedef struct packed {
    logic [NUM_TMR-1:0]   runOk;     // per-timer combined run condition
    logic [NUM_TMR-1:0]   startNow;  // clear counter this cycle
    logic [NUM_PAIRS-1:0] joined;    // pair counts as one 16-bit value
    logic [NUM_PAIRS-1:0] chainOdd;  // odd timer advances on even match
  } ctlStrobe_t;
endpackage

// File: rtl/tmrbank_ctrl.sv
module tmrbank_ctrl
  import tmrbank_pkg::*;
(
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [ADDR_W-1:0]                 regAddr,
  input  logic                              regWr,
  input  logic [BYTE_W-1:0]                 regWdata,
  output logic [BYTE_W-1:0]                 regRdata,
  output logic [NUM_TMR-1:0][BYTE_W-1:0]    matchVal,
  output ctlStrobe_t                        strobe
);
  logic [NUM_TMR-1:0][BYTE_W-1:0] matchReg;
  logic [BYTE_W-1:0]              clkSelReg;
  logic [NUM_PAIRS-1:0]           modeReg;
  logic [NUM_TMR-1:0]             runReg;
  logic                           globalRun;

  logic                           wrRun;
  logic [NUM_TMR-1:0]             runOkNow;
  logic [NUM_TMR-1:0]             runOkNew;

  assign wrRun    = regWr && (regAddr == OFS_RUN);
  assign runOkNow = runReg & {NUM_TMR{globalRun}};
  assign runOkNew = regWdata[NUM_TMR-1:0] & {NUM_TMR{regWdata[GLOBAL_RUN_BIT]}};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      matchReg  <= '0;
      clkSelReg <= '0;
      modeReg   <= '0;
      runReg    <= '0;
      globalRun <= 1'b0;
    end else if (regWr) begin
      for (int i = 0; i < NUM_TMR; i++) begin
        if (regAddr == ADDR_W'(i)) matchReg[i] <= regWdata;
      end
      if (regAddr == OFS_CLKSEL) clkSelReg <= regWdata;
      if (regAddr == OFS_MODE)   modeReg   <= regWdata[NUM_PAIRS-1:0];
      if (regAddr == OFS_RUN) begin
        runReg    <= regWdata[NUM_TMR-1:0];
        globalRun <= regWdata[GLOBAL_RUN_BIT];
      end
    end
  end

  always_comb begin
    regRdata = '0;
    for (int i = 0; i < NUM_TMR; i++) begin
      if (regAddr == ADDR_W'(i)) regRdata = matchReg[i];
    end
    if (regAddr == OFS_CLKSEL) regRdata = clkSelReg;
    if (regAddr == OFS_MODE)   regRdata[NUM_PAIRS-1:0] = modeReg;
    if (regAddr == OFS_RUN) begin
      regRdata[NUM_TMR-1:0]      = runReg;
      regRdata[GLOBAL_RUN_BIT]   = globalRun;
    end
  end

  assign matchVal        = matchReg;
  assign strobe.runOk    = runOkNow;
  assign strobe.startNow = wrRun ? (runOkNew & ~runOkNow) : '0;
  assign strobe.joined   = modeReg;

  genvar p;
  generate
    for (p = 0; p < NUM_PAIRS; p++) begin : g_sel
      localparam int ODD_LSB = (2 * p + 1) * CLK_FIELD_W;
      assign strobe.chainOdd[p] = (clkSelReg[ODD_LSB +: CLK_FIELD_W] == '0);
    end
  endgenerate
endmodule

// File: rtl/tmrbank_dp.sv
module tmrbank_dp
  import tmrbank_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           tick,
  input  ctlStrobe_t                     strobe,
  input  logic [NUM_TMR-1:0][BYTE_W-1:0] matchVal,
  output logic [NUM_TMR-1:0]             irq
);
  logic [NUM_TMR-1:0] hitNow;

  genvar p;
  generate
    for (p = 0; p < NUM_PAIRS; p++) begin : g_pair
      localparam int EV = 2 * p;
      localparam int OD = 2 * p + 1;

      logic [BYTE_W-1:0] loCnt, hiCnt, loNext, hiNext;
      logic              loEq, hiEq, evHit, odHit, odClk;

      always_comb begin
        loEq   = (loCnt == matchVal[EV]);
        hiEq   = (hiCnt == matchVal[OD]);
        loNext = loCnt;
        hiNext = hiCnt;
        evHit  = 1'b0;
        odHit  = 1'b0;
        odClk  = 1'b0;
        if (strobe.joined[p]) begin
          if (strobe.startNow[EV]) begin
            loNext = '0;
            hiNext = '0;
          end else if (strobe.runOk[EV] && tick) begin
            if (loEq && hiEq) begin
              evHit  = 1'b1;
              loNext = '0;
              hiNext = '0;
            end else begin
              loNext = loCnt + 1'b1;
              if (&loCnt) hiNext = hiCnt + 1'b1;
            end
          end
        end else begin
          if (strobe.startNow[EV]) begin
            loNext = '0;
          end else if (strobe.runOk[EV] && tick) begin
            if (loEq) begin
              evHit  = 1'b1;
              loNext = '0;
            end else begin
              loNext = loCnt + 1'b1;
            end
          end
          odClk = strobe.chainOdd[p] ? evHit : tick;
          if (strobe.startNow[OD]) begin
            hiNext = '0;
          end else if (strobe.runOk[OD] && odClk) begin
            if (hiEq) begin
              odHit  = 1'b1;
              hiNext = '0;
            end else begin
              hiNext = hiCnt + 1'b1;
            end
          end
        end
      end

      always_ff @(posedge clk) begin
        if (!rstN) begin
          loCnt <= '0;
          hiCnt <= '0;
        end else begin
          loCnt <= loNext;
          hiCnt <= hiNext;
        end
      end

      assign hitNow[EV] = evHit;
      assign hitNow[OD] = odHit;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) irq <= '0;
    else       irq <= hitNow;
  end
endmodule

// File: rtl/tmrbank_top.sv
module tmrbank_top
  import tmrbank_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic [BYTE_W-1:0] regWdata,
  output logic [BYTE_W-1:0] regRdata,
  input  logic              tick,
  output logic [NUM_TMR-1:0] irq
);
  ctlStrobe_t                     strobe;
  logic [NUM_TMR-1:0][BYTE_W-1:0] matchVal;
  logic [NUM_TMR-1:0]             runOkTap;
  logic [NUM_PAIRS-1:0]           joinedTap;

  tmrbank_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .regAddr  (regAddr),
    .regWr    (regWr),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .matchVal (matchVal),
    .strobe   (strobe)
  );

  tmrbank_dp dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .tick     (tick),
    .strobe   (strobe),
    .matchVal (matchVal),
    .irq      (irq)
  );

  assign runOkTap  = strobe.runOk;
  assign joinedTap = strobe.joined;
endmodule

// File: rtl/tmrbank_chk.sv
module tmrbank_chk
  import tmrbank_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 tick,
  input logic [NUM_TMR-1:0]   irq,
  input logic [NUM_TMR-1:0]   runOk,
  input logic [NUM_PAIRS-1:0] joined
);
  // R3: no tick, no request on the following cycle
  assert_no_tick_no_irq_R3: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> (irq == '0));

  // R3: a timer that is not running raises nothing
  assert_idle_t0_silent_R3: assert property (@(posedge clk) disable iff (!rstN)
    !runOk[0] |=> !irq[0]);
  assert_idle_t1_silent_R3: assert property (@(posedge clk) disable iff (!rstN)
    !runOk[1] |=> !irq[1]);
  assert_idle_t2_silent_R3: assert property (@(posedge clk) disable iff (!rstN)
    !runOk[2] |=> !irq[2]);
  assert_idle_t3_silent_R3: assert property (@(posedge clk) disable iff (!rstN)
    !runOk[3] |=> !irq[3]);

  // R8: a joined pair never raises its odd request
  assert_joined_odd_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    joined[0] |=> !irq[1]);
  assert_joined_odd_quiet2_R8: assert property (@(posedge clk) disable iff (!rstN)
    joined[1] |=> !irq[3]);
endmodule

bind tmrbank_top tmrbank_chk chk_i (
  .clk    (clk),
  .rstN   (rstN),
  .tick   (tick),
  .irq    (irq),
  .runOk  (runOkTap),
  .joined (joinedTap)
);

// File: tb/tmrbank_tb.sv
module tmrbank_top_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] regAddr = '0;
  logic       regWr = 1'b0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic       tick = 1'b0;
  logic [3:0] irq;

  int checks = 0;
  int errors = 0;
  int hits[4];
  int first[4];

  always #10 clk = ~clk;

  tmrbank_top dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr),
    .regWdata(regWdata), .regRdata(regRdata), .tick(tick), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [2:0] a, input logic [7:0] d);
    regAddr = a; regWdata = d; regWr = 1'b1;
    @(posedge clk); @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rdReg(input logic [2:0] a, output int v);
    regAddr = a;
    #1 v = regRdata;
  endtask

  task automatic clearHits();
    for (int t = 0; t < 4; t++) begin hits[t] = 0; first[t] = 0; end
  endtask

  task automatic runTicks(input int n);
    clearHits();
    for (int k = 1; k <= n; k++) begin
      tick = 1'b1;
      @(posedge clk); @(negedge clk);
      for (int t = 0; t < 4; t++) begin
        if (irq[t]) begin
          hits[t]++;
          if (first[t] == 0) first[t] = k;
        end
      end
    end
    tick = 1'b0;
  endtask

  task automatic restart(input logic [7:0] runVal);
    wrReg(3'd6, 8'h00);
    wrReg(3'd6, runVal);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog R1 actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int v;
    int mv[4];
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rdReg(3'(a), v);
      chk($sformatf("R1 reg %0d after reset", a), v, 0);
    end
    chk("R1 irq after reset", int'(irq), 0);

    // R2 register map
    wrReg(3'd0, 8'h11); wrReg(3'd1, 8'h22); wrReg(3'd2, 8'h33); wrReg(3'd3, 8'h44);
    wrReg(3'd4, 8'hA5); wrReg(3'd5, 8'hFF); wrReg(3'd6, 8'h7F);
    rdReg(3'd0, v); chk("R2 match0", v, 'h11);
    rdReg(3'd1, v); chk("R2 match1", v, 'h22);
    rdReg(3'd2, v); chk("R2 match2", v, 'h33);
    rdReg(3'd3, v); chk("R2 match3", v, 'h44);
    rdReg(3'd4, v); chk("R2 clksel", v, 'hA5);
    rdReg(3'd5, v); chk("R2 mode", v, 'h03);
    rdReg(3'd6, v); chk("R2 run", v, 'h0F);
    rdReg(3'd7, v); chk("R2 unused", v, 0);
    wrReg(3'd6, 8'hF0);
    rdReg(3'd6, v); chk("R2 run global", v, 'h80);
    wrReg(3'd5, 8'h00);
    wrReg(3'd4, 8'h55);   // every field 01: all timers on tick

    // R5 / R6 sweep of match values on all four timers in parallel
    for (int m = 0; m <= 31; m++) begin
      int base;
      base = (m == 31) ? 248 : m;
      mv[0] = base; mv[1] = base + 3; mv[2] = base + 5; mv[3] = base + 7;
      for (int t = 0; t < 4; t++) wrReg(3'(t), 8'(mv[t]));
      restart(8'h8F);
      n = 3 * (base + 8);
      runTicks(n);
      for (int t = 0; t < 4; t++) begin
        chk($sformatf("R5 count t%0d M=%0d", t, mv[t]), hits[t], n / (mv[t] + 1));
        chk($sformatf("R6 first pulse t%0d M=%0d", t, mv[t]), first[t], mv[t] + 1);
      end
    end

    // R3 global run clear: nothing moves
    for (int t = 0; t < 4; t++) wrReg(3'(t), 8'h00);
    restart(8'h0F);
    runTicks(40);
    for (int t = 0; t < 4; t++) chk($sformatf("R3 global off t%0d", t), hits[t], 0);
    // R3 tick low: nothing moves
    wrReg(3'd6, 8'h8F);
    clearHits();
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      for (int t = 0; t < 4; t++) if (irq[t]) hits[t]++;
    end
    for (int t = 0; t < 4; t++) chk($sformatf("R3 tick low t%0d", t), hits[t], 0);
    runTicks(1);
    for (int t = 0; t < 4; t++) chk($sformatf("R3 one tick M=0 t%0d", t), hits[t], 1);
    // R3 single run bit
    restart(8'h84);
    runTicks(5);
    chk("R3 only t2 runs t0", hits[0], 0);
    chk("R3 only t2 runs t2", hits[2], 5);
    chk("R3 only t2 runs t3", hits[3], 0);

    // R4 start, same-value rewrite, stop, restart
    wrReg(3'd0, 8'd9);
    restart(8'h81);
    runTicks(5);
    wrReg(3'd6, 8'h81);
    runTicks(5);
    chk("R4 rewrite keeps count", first[0], 5);
    runTicks(4);
    wrReg(3'd6, 8'h80);
    runTicks(30);
    chk("R4 stopped timer silent", hits[0], 0);
    wrReg(3'd6, 8'h81);
    runTicks(10);
    chk("R4 restart from zero", first[0], 10);
    runTicks(3);
    wrReg(3'd6, 8'h01);
    wrReg(3'd6, 8'h81);
    runTicks(10);
    chk("R4 global toggle restarts", first[0], 10);

    // R7 cascade: T1 chained, T3 on tick
    wrReg(3'd0, 8'd2); wrReg(3'd1, 8'd3); wrReg(3'd2, 8'd2); wrReg(3'd3, 8'd3);
    wrReg(3'd4, 8'h40);
    restart(8'h8F);
    runTicks(48);
    chk("R7 t0 base", hits[0], 16);
    chk("R7 t1 chained count", hits[1], 4);
    chk("R7 t1 chained first", first[1], 12);
    chk("R7 t3 tick count", hits[3], 12);
    chk("R7 t3 tick first", first[3], 4);
    wrReg(3'd4, 8'h04);
    restart(8'h8F);
    runTicks(48);
    chk("R7 t1 tick count", hits[1], 12);
    chk("R7 t3 chained count", hits[3], 4);
    chk("R7 t3 chained first", first[3], 12);
    wrReg(3'd4, 8'h55);

    // R8 16-bit pairs
    wrReg(3'd5, 8'h01);
    wrReg(3'd0, 8'h05); wrReg(3'd1, 8'h01);
    restart(8'h81);
    runTicks(600);
    chk("R8 joined count", hits[0], 2);
    chk("R8 joined first", first[0], 262);
    chk("R8 odd request quiet", hits[1], 0);
    wrReg(3'd0, 8'hFF); wrReg(3'd1, 8'h00);
    restart(8'h81);
    runTicks(300);
    chk("R8 low byte ff first", first[0], 256);
    wrReg(3'd5, 8'h02);
    wrReg(3'd2, 8'h00); wrReg(3'd3, 8'h01);
    restart(8'h84);
    runTicks(300);
    chk("R8 pair1 first", first[2], 257);
    chk("R8 pair1 count", hits[2], 1);
    chk("R8 pair1 odd quiet", hits[3], 0);
    wrReg(3'd5, 8'h00);

    // R9 match value rewritten while running
    wrReg(3'd2, 8'd9);
    restart(8'h84);
    runTicks(4);
    wrReg(3'd2, 8'd5);
    runTicks(10);
    chk("R9 raised-late first", first[2], 2);
    chk("R9 raised-late count", hits[2], 2);
    wrReg(3'd2, 8'd9);
    restart(8'h84);
    runTicks(7);
    wrReg(3'd2, 8'd3);
    runTicks(260);
    chk("R9 below count wraps first", first[2], 253);
    chk("R9 below count wraps count", hits[2], 2);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule